// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers fifteen active-high interrupt request lines, numbered 1 to 15, into latched pending bits. It gates them with a per-source enable mask and hands the single winning source to one processor as a registered 4-bit request number. The value 0 on that output means that nothing is requested. Each source belongs to one of two priority levels. Any enabled pending source at the high level beats every source at the low level. Within a level, the larger number wins.

Software programs the block through an APB slave port (no wait states) with four word registers. The level register sits at offset 0x00, with bit n = 1 placing source n at the high level. The pending register sits at 0x04; it reads the latched bits, and writing ones to it forces those bits set. The clear register sits at 0x0C, where writing ones clears the matching pending bits and reads return zero. The mask register sits at 0x40, with bit n = 1 enabling source n. A pending bit can also be cleared by the processor's acknowledge port, which presents the number of the source being serviced.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Reset is synchronous and active-high. It clears the level, mask and pending registers and drives the request output to 0.
- R2: A request line sampled high at a rising clock edge sets its pending bit at that edge. The bit is visible in the pending register (offset 0x04) from then on.
- R3: A pending bit stays set after its request line falls, until it is cleared by a clear write or by an acknowledge.
- R4: An APB write to offset 0x0C clears each pending bit whose data bit is 1 and leaves bits written 0 unchanged. Reading offset 0x0C returns 0.
- R5: An acknowledge (`ack_valid` high with `ack_id` = n) clears pending bit n at that clock edge. If request line n is high at the same edge, the bit stays set.
- R6: Only sources whose bit in the mask register (offset 0x40) is 1 can be requested. With no enabled pending source, the request output is 0.
- R7: If any enabled pending source has its bit set in the level register (offset 0x00), the request output carries the highest-numbered such source.
- R8: If no enabled pending source is at the high level, the request output carries the highest-numbered enabled pending source at the low level.
- R9: The request output is registered. It reflects the pending, mask and level state one clock edge after that state changes.
- R10: An APB write to offset 0x04 sets every pending bit whose data bit is 1 and clears none.
- R11: Bit 0 of every register reads as 0 and cannot be set. An acknowledge of number 0 has no effect. Reads of offsets outside the map return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid during the access phase |
| irq_in | input | 15 | Request lines for sources 15 down to 1 |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_id | input | 4 | Number of the source being acknowledged |
| irq_req | output | 4 | Winning source number, 0 when idle |

## Verification
A request line, a register write or an acknowledge changes the pending and mask state at the rising edge that samples it, so register readback is taken during the access phase of a later read. The request number follows one edge after that state change. The tasks therefore sample it at the falling edge after the next rising edge, and one check confirms that the old value is still present half a cycle after a mask write. Each scenario drives its inputs at falling edges and returns them to idle before the next edge, so every stimulus lasts exactly one sampling edge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int IRQ_NUM_SRC = 15;
    localparam int IRQ_VEC_W   = IRQ_NUM_SRC + 1;
    localparam int IRQ_ID_W    = $clog2(IRQ_VEC_W);
    localparam int APB_ADDR_W  = 8;
    localparam int APB_DATA_W  = 32;

    localparam logic [APB_ADDR_W-1:0] OFS_LEVEL = 8'h00;
    localparam logic [APB_ADDR_W-1:0] OFS_PEND  = 8'h04;
    localparam logic [APB_ADDR_W-1:0] OFS_CLEAR = 8'h0C;
    localparam logic [APB_ADDR_W-1:0] OFS_MASK  = 8'h40;

    typedef logic [IRQ_VEC_W-1:0] irq_vec_t;
    typedef logic [IRQ_ID_W-1:0]  irq_id_t;

    // Software-originated changes to the pending bits
    typedef struct packed {
        irq_vec_t set;
        irq_vec_t clr;
    } pend_upd_t;

    // Result of one priority search
    typedef struct packed {
        logic    found;
        irq_id_t id;
    } pick_t;

    // Vector with bit 0 forced low (source 0 does not exist)
    localparam irq_vec_t SRC_BITS = ~irq_vec_t'(1);

    function automatic pick_t pick_highest(input irq_vec_t v);
        pick_t p;
        p.found = 1'b0;
        p.id    = '0;
        for (int i = 1; i < IRQ_VEC_W; i++) begin
            if (v[i]) begin
                p.found = 1'b1;
                p.id    = irq_id_t'(i);
            end
        end
        return p;
    endfunction

    function automatic irq_vec_t id_to_vec(input irq_id_t id);
        irq_vec_t v;
        v     = '0;
        v[id] = 1'b1;
        return v & SRC_BITS;
    endfunction

endpackage

// File: rtl/irq_apb_regs.sv
module irq_apb_regs
    import irq_prio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  psel,
    input  logic                  penable,
    input  logic                  pwrite,
    input  logic [APB_ADDR_W-1:0] paddr,
    input  logic [APB_DATA_W-1:0] pwdata,
    input  irq_vec_t              pend_q,
    output irq_vec_t              level_q,
    output irq_vec_t              mask_q,
    output pend_upd_t             sw_upd,
    output logic [APB_DATA_W-1:0] prdata
);

    logic     wr_en;
    irq_vec_t wr_bits;

    assign wr_en   = psel && penable && pwrite;
    assign wr_bits = pwdata[IRQ_VEC_W-1:0] & SRC_BITS;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            if (paddr == OFS_LEVEL) level_q <= wr_bits;
            if (paddr == OFS_MASK)  mask_q  <= wr_bits;
        end
    end

    always_comb begin
        sw_upd.set = '0;
        sw_upd.clr = '0;
        if (wr_en && paddr == OFS_PEND)  sw_upd.set = wr_bits;
        if (wr_en && paddr == OFS_CLEAR) sw_upd.clr = wr_bits;
    end

    always_comb begin
        prdata = '0;
        if (psel) begin
            case (paddr)
                OFS_LEVEL: prdata = APB_DATA_W'(level_q);
                OFS_PEND:  prdata = APB_DATA_W'(pend_q);
                OFS_MASK:  prdata = APB_DATA_W'(mask_q);
                default:   prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank
    import irq_prio_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_vec_t  line_vec,
    input  pend_upd_t sw_upd,
    input  logic      ack_valid,
    input  irq_id_t   ack_id,
    output irq_vec_t  pend_q,
    output irq_vec_t  clr_vec
);

    irq_vec_t set_vec;
    irq_vec_t pend_d;

    assign clr_vec = sw_upd.clr | (ack_valid ? id_to_vec(ack_id) : '0);
    assign set_vec = (line_vec | sw_upd.set) & SRC_BITS;
    // A set in the same cycle wins over any clear
    assign pend_d  = ((pend_q & ~clr_vec) | set_vec) & SRC_BITS;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_prio_pkg::*;
#(
    parameter int NUM_LEVELS = 2
)(
    input  irq_vec_t pend,
    input  irq_vec_t mask,
    input  irq_vec_t level,
    output pick_t    winner
);

    localparam int TOP_LVL = NUM_LEVELS - 1;

    irq_vec_t                  active;
    pick_t [NUM_LEVELS-1:0]    lvl_pick;

    assign active = pend & mask & SRC_BITS;

    // Level index 1 holds sources with their level bit set, index 0 the rest
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        irq_vec_t cand;
        assign cand        = (g == TOP_LVL) ? (active & level) : (active & ~level);
        assign lvl_pick[g] = pick_highest(cand);
    end

    assign winner = lvl_pick[TOP_LVL].found ? lvl_pick[TOP_LVL] : lvl_pick[0];

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   psel,
    input  logic                   penable,
    input  logic                   pwrite,
    input  logic [APB_ADDR_W-1:0]  paddr,
    input  logic [APB_DATA_W-1:0]  pwdata,
    output logic [APB_DATA_W-1:0]  prdata,
    input  logic [IRQ_NUM_SRC:1]   irq_in,
    input  logic                   ack_valid,
    input  logic [IRQ_ID_W-1:0]    ack_id,
    output logic [IRQ_ID_W-1:0]    irq_req
);

    irq_vec_t  line_vec;
    irq_vec_t  pend_q;
    irq_vec_t  level_q;
    irq_vec_t  mask_q;
    irq_vec_t  clr_vec;
    pend_upd_t sw_upd;
    pick_t     winner;

    assign line_vec = {irq_in, 1'b0};

    irq_apb_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .pend_q  (pend_q),
        .level_q (level_q),
        .mask_q  (mask_q),
        .sw_upd  (sw_upd),
        .prdata  (prdata)
    );

    irq_pending_bank u_pend (
        .clk       (clk),
        .rst       (rst),
        .line_vec  (line_vec),
        .sw_upd    (sw_upd),
        .ack_valid (ack_valid),
        .ack_id    (ack_id),
        .pend_q    (pend_q),
        .clr_vec   (clr_vec)
    );

    irq_prio_select #(.NUM_LEVELS(2)) u_sel (
        .pend   (pend_q),
        .mask   (mask_q),
        .level  (level_q),
        .winner (winner)
    );

    always_ff @(posedge clk) begin
        if (rst)               irq_req <= '0;
        else if (winner.found) irq_req <= winner.id;
        else                   irq_req <= '0;
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  psel,
    input logic                  penable,
    input logic                  pwrite,
    input logic [APB_ADDR_W-1:0] paddr,
    input logic [APB_DATA_W-1:0] pwdata,
    input logic [APB_DATA_W-1:0] prdata,
    input logic [IRQ_NUM_SRC:1]  irq_in,
    input logic                  ack_valid,
    input logic [IRQ_ID_W-1:0]   ack_id,
    input logic [IRQ_ID_W-1:0]   irq_req,
    input irq_vec_t              pend_q,
    input irq_vec_t              mask_q,
    input irq_vec_t              level_q,
    input irq_vec_t              clr_vec
);

    logic     live_q;
    irq_vec_t prev_act, prev_hi, prev_set, prev_clr, prev_pend, prev_ack;
    irq_vec_t set_now, ack_now;

    always_comb begin
        set_now = {irq_in, 1'b0};
        if (psel && penable && pwrite && paddr == OFS_PEND)
            set_now = set_now | pwdata[IRQ_VEC_W-1:0];
        set_now = set_now & SRC_BITS;
        ack_now = '0;
        for (int i = 1; i < IRQ_VEC_W; i++)
            if (ack_valid && int'(ack_id) == i) ack_now[i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q    <= 1'b0;
            prev_act  <= '0;
            prev_hi   <= '0;
            prev_set  <= '0;
            prev_clr  <= '0;
            prev_pend <= '0;
            prev_ack  <= '0;
        end else begin
            live_q    <= 1'b1;
            prev_act  <= pend_q & mask_q;
            prev_hi   <= pend_q & mask_q & level_q;
            prev_set  <= set_now;
            prev_clr  <= clr_vec;
            prev_pend <= pend_q;
            prev_ack  <= ack_now;
        end
    end

    AST_LINE_SETS: assert property (@(posedge clk) disable iff (rst)
        live_q |-> ((pend_q & prev_set) == prev_set));                 // R2
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        live_q |-> ((prev_pend & ~prev_clr & ~pend_q) == '0));         // R3
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        live_q |-> ((pend_q & prev_ack & ~prev_set) == '0));           // R5
    AST_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (live_q && prev_act == '0) |-> (irq_req == '0));               // R6
    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (live_q && irq_req != '0) |-> prev_act[irq_req]);              // R6
    AST_REQ_HIGH_FIRST: assert property (@(posedge clk) disable iff (rst)
        (live_q && prev_hi != '0) |-> prev_hi[irq_req]);               // R7
    AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (rst)
        psel |-> (prdata[0] == 1'b0));                                 // R11

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk chk_i (.*);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
    import irq_prio_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [15:0] irq_vec = '0;
    logic        ack_valid = 1'b0;
    logic [3:0]  ack_id = '0;
    logic [3:0]  irq_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_prio_ctrl dut_i (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_in(irq_vec[15:1]),
        .ack_valid(ack_valid), .ack_id(ack_id), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk); penable = 1; #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    task automatic pulse_irq(input logic [15:0] v);
        @(negedge clk); irq_vec = v;
        @(negedge clk); irq_vec = '0;
    endtask

    task automatic ack(input logic [3:0] id, input logic [15:0] lines);
        @(negedge clk); ack_valid = 1; ack_id = id; irq_vec = lines;
        @(negedge clk); ack_valid = 0; ack_id = '0; irq_vec = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R1 request after reset", 32'(irq_req), 0);
        apb_read(OFS_LEVEL, d); check("R1 level after reset", d, 0);
        apb_read(OFS_PEND, d);  check("R1 pending after reset", d, 0);
        apb_read(OFS_MASK, d);  check("R1 mask after reset", d, 0);
    endtask

    task automatic t_sticky_and_clear();
        logic [31:0] d;
        do_reset();
        pulse_irq(16'h0020);
        pulse_irq(16'h0200);
        apb_read(OFS_PEND, d); check("R2 lines latched", d, 32'h0220);
        repeat (5) @(negedge clk);
        apb_read(OFS_PEND, d); check("R3 still pending", d, 32'h0220);
        apb_write(OFS_CLEAR, 32'h0);
        apb_read(OFS_PEND, d); check("R4 zero clear no effect", d, 32'h0220);
        apb_write(OFS_CLEAR, 32'h0020);
        apb_read(OFS_PEND, d); check("R4 bit5 cleared", d, 32'h0200);
        apb_read(OFS_CLEAR, d); check("R4 clear reads zero", d, 0);
        // mask gating and registered output
        repeat (2) @(negedge clk);
        check("R6 masked gives no request", 32'(irq_req), 0);
        apb_write(OFS_MASK, 32'h0200);
        check("R9 old value before next edge", 32'(irq_req), 0);
        @(negedge clk);
        check("R9 request one edge later", 32'(irq_req), 9);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        do_reset();
        pulse_irq(16'h1088);            // sources 3, 7, 12
        apb_write(OFS_MASK, 32'hFFFE);
        @(negedge clk);
        check("R8 low level highest number", 32'(irq_req), 12);
        apb_write(OFS_LEVEL, 32'h0008);
        @(negedge clk);
        check("R7 high level beats higher number", 32'(irq_req), 3);
        apb_write(OFS_LEVEL, 32'h0088);
        @(negedge clk);
        check("R7 highest within high level", 32'(irq_req), 7);
        apb_write(OFS_MASK, 32'hFF7E);
        @(negedge clk);
        check("R6 masked high source skipped", 32'(irq_req), 3);
        apb_write(OFS_CLEAR, 32'h0008);
        @(negedge clk);
        check("R8 fallback to low level", 32'(irq_req), 12);
        do_reset();
        check("R1 request cleared by reset", 32'(irq_req), 0);
        apb_read(OFS_PEND, d); check("R1 pending cleared by reset", d, 0);
    endtask

    task automatic t_ack();
        logic [31:0] d;
        do_reset();
        pulse_irq(16'h0050);            // sources 4, 6
        apb_write(OFS_MASK, 32'hFFFF);
        @(negedge clk);
        check("R8 pre-ack winner", 32'(irq_req), 6);
        ack(4'd6, 16'h0);
        apb_read(OFS_PEND, d); check("R5 ack clears bit6", d, 32'h0010);
        check("R5 next winner after ack", 32'(irq_req), 4);
        ack(4'd4, 16'h0010);
        apb_read(OFS_PEND, d); check("R5 line set beats ack", d, 32'h0010);
        ack(4'd0, 16'h0);
        apb_read(OFS_PEND, d); check("R11 ack of zero ignored", d, 32'h0010);
    endtask

    task automatic t_force_and_map();
        logic [31:0] d;
        do_reset();
        apb_write(OFS_PEND, 32'h8001);
        apb_read(OFS_PEND, d); check("R10 forced set, R11 bit0", d, 32'h8000);
        apb_write(OFS_PEND, 32'h0002);
        apb_read(OFS_PEND, d); check("R10 write does not clear", d, 32'h8002);
        apb_write(OFS_MASK, 32'hFFFF);
        apb_read(OFS_MASK, d); check("R11 mask bit0 zero", d, 32'hFFFE);
        apb_write(OFS_LEVEL, 32'h0001);
        apb_read(OFS_LEVEL, d); check("R11 level bit0 zero", d, 0);
        apb_read(8'h20, d); check("R11 unmapped reads zero", d, 0);
        check("R10 forced source requested", 32'(irq_req), 15);
    endtask

    initial begin
        t_reset();
        t_sticky_and_clear();
        t_priority();
        t_ack();
        t_force_and_map();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule